// File: doc/BRIEF.md
# Fixed-Point Sigmoid Interpolator

This block evaluates the logistic function 1/(1+e^-x) on a two's-complement input that carries `XEXP` fractional bits (6 by default), so an input code of 64 stands for 1.0. A small table is built at elaboration time. It holds the function's value at `ENTRIES` evenly spaced non-negative breakpoints, one every 2^`SEG_SHIFT` input codes. Each value is rounded to `YEXP` fractional bits (12 by default, so one is 4096).

The block folds the input to its magnitude and finds the segment that holds it. It adds a truncated linear share of the step between the two neighbouring table entries. For a negative input the folded result is subtracted from one. Magnitudes at or past the last breakpoint saturate.

The unit is a three-stage pipeline with a valid bit. It takes one sample per clock and needs no back-pressure, which suits element-wise activation streams.

Top module: `sigmoid_interp`

## Requirements
- R1: While reset (`rstN` low) is held and after it is released, `outValid` reads 0 and `outY` reads 0 until the first sample reaches the output.
- R2: A sample taken with `inValid` high at a rising edge shows up with `outValid` high right after the third rising edge, counting the sampling edge as the first. Samples may arrive on every cycle back to back.
- R3: An input of 0 gives exactly half of full scale, which is 2048 with the defaults.
- R4: An input that is a non-negative multiple of 64 below 448 (breakpoint i = x/64) gives round(4096/(1+e^-i)). The table is 2048, 2994, 3608, 3902, 4022, 4069, 4086, 4092.
- R5: For 0 < x < 448 that is not a breakpoint, the output is T[i] + floor((T[i+1]-T[i])·f/64). Here i is x/64 and f is the low 6 bits of x.
- R6: A negative input x gives 4096 minus the result for |x|. This includes the most negative code -32768, whose magnitude is 32768.
- R7: An input with |x| ≥ 448 gives the last entry, 4092, for positive x and 4 for negative x.
- R8: While no valid sample reaches the last stage, `outValid` is 0 and `outY` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Qualifies `inX` in this cycle |
| inX | input | IN_W (16) | Signed input, XEXP fractional bits |
| outValid | output | 1 | Qualifies `outY` |
| outY | output | YEXP+1 (13) | Unsigned result, YEXP fractional bits |

## Verification
The hardest case to reach is the boundary where interpolation hands over to saturation. At input 447 the segment index is the last one still interpolating and the fraction is at its maximum. At 448 the next table slot would run past the table, so the design must not read it. The stimulus drives 447, 448, their negatives and both extreme codes back to back, so the switch between segment and saturation paths happens on consecutive pipeline slots. Gaps in `inValid` and a reset taken mid-stream show that held output data is never refreshed by empty slots.

// File: rtl/sigmoid_interp_pkg.sv
package sigmoid_interp_pkg;

  typedef struct packed {
    logic foldEn;   // stage 1 captures the folded input
    logic lookEn;   // stage 2 captures table operands
    logic mixEn;    // stage 3 captures the interpolated result
  } stageStrobes_t;

  // logistic value at breakpoint idx, rounded to yexp fractional bits
  function automatic int sigEntry(int idx, int segShift, int xexp, int yexp);
    real x;
    real term;
    real ex;
    real s;
    x = real'(idx) * (2.0 ** (segShift - xexp));
    term = 1.0;
    ex = 1.0;
    for (int k = 1; k < 80; k++) begin
      term = term * x / real'(k);
      ex = ex + term;
    end
    s = ex / (1.0 + ex);
    return $rtoi(s * (2.0 ** yexp) + 0.5);
  endfunction

endpackage

// File: rtl/sigmoid_ctrl.sv
module sigmoid_ctrl
  import sigmoid_interp_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output stageStrobes_t strobes,
  output logic          outValid
);

  logic vld1;
  logic vld2;
  logic vld3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld1 <= 1'b0;
      vld2 <= 1'b0;
      vld3 <= 1'b0;
    end else begin
      vld1 <= inValid;
      vld2 <= vld1;
      vld3 <= vld2;
    end
  end

  always_comb begin
    strobes.foldEn = inValid;
    strobes.lookEn = vld1;
    strobes.mixEn  = vld2;
  end

  assign outValid = vld3;

  // R2: every accepted sample emerges after exactly three edges
  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 outValid);

endmodule

// File: rtl/sigmoid_datapath.sv
module sigmoid_datapath
  import sigmoid_interp_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int XEXP      = 6,
  parameter int YEXP      = 12,
  parameter int ENTRIES   = 8,
  parameter int SEG_SHIFT = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  stageStrobes_t       strobes,
  input  logic [IN_W-1:0]     inX,
  output logic [YEXP:0]       outY
);

  localparam int OUT_W  = YEXP + 1;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int HI_W   = IN_W - SEG_SHIFT;
  localparam int PROD_W = OUT_W + SEG_SHIFT;
  localparam logic [OUT_W-1:0] ONE  = OUT_W'(1) << YEXP;
  localparam logic [OUT_W-1:0] HALF = OUT_W'(1) << (YEXP - 1);

  logic [OUT_W-1:0] lut [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_lut
    localparam logic [OUT_W-1:0] ENTRY = OUT_W'(sigEntry(g, SEG_SHIFT, XEXP, YEXP));
    assign lut[g] = ENTRY;
  end

  // stage 1: fold sign
  logic            negC;
  logic [IN_W-1:0] magC;
  logic            negS1;
  logic [IN_W-1:0] magS1;

  assign negC = inX[IN_W-1];
  assign magC = negC ? (~inX + 1'b1) : inX;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      negS1 <= 1'b0;
      magS1 <= '0;
    end else if (strobes.foldEn) begin
      negS1 <= negC;
      magS1 <= magC;
    end
  end

  // stage 2: segment lookup
  logic [HI_W-1:0]      hiPart;
  logic                 satC;
  logic [IDX_W-1:0]     idxSel;
  logic [IDX_W-1:0]     idxNext;
  logic [OUT_W-1:0]     baseC;
  logic [OUT_W-1:0]     diffC;
  logic [OUT_W-1:0]     baseS2;
  logic [OUT_W-1:0]     diffS2;
  logic [SEG_SHIFT-1:0] fracS2;
  logic                 negS2;
  logic                 satS2;

  assign hiPart  = magS1[IN_W-1:SEG_SHIFT];
  assign satC    = hiPart >= HI_W'(ENTRIES - 1);
  assign idxSel  = satC ? IDX_W'(ENTRIES - 1) : hiPart[IDX_W-1:0];
  assign idxNext = idxSel + 1'b1;
  assign baseC   = lut[idxSel];
  assign diffC   = satC ? '0 : (lut[idxNext] - lut[idxSel]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseS2 <= '0;
      diffS2 <= '0;
      fracS2 <= '0;
      negS2  <= 1'b0;
      satS2  <= 1'b0;
    end else if (strobes.lookEn) begin
      baseS2 <= baseC;
      diffS2 <= diffC;
      fracS2 <= satC ? '0 : magS1[SEG_SHIFT-1:0];
      negS2  <= negS1;
      satS2  <= satC;
    end
  end

  // stage 3: interpolate and unfold
  logic [PROD_W-1:0] prod;
  logic [OUT_W-1:0]  posY;

  assign prod = PROD_W'(diffS2) * PROD_W'(fracS2);
  assign posY = baseS2 + OUT_W'(prod >> SEG_SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outY <= '0;
    else if (strobes.mixEn) outY <= negS2 ? (ONE - posY) : posY;
  end

  // R8: empty slots never disturb the held result
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.mixEn |=> $stable(outY));

  // R6: folded negative inputs land at or below one half
  a_r6_neg_low: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.mixEn && negS2) |=> (outY <= HALF));

  // R4: non-negative inputs land at or above one half
  a_r4_pos_high: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.mixEn && !negS2) |=> (outY >= HALF));

  // R7: saturated positive inputs give the last entry
  a_r7_sat_last: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.mixEn && satS2 && !negS2) |=> (outY == lut[ENTRIES-1]));

endmodule

// File: rtl/sigmoid_interp.sv
module sigmoid_interp
  import sigmoid_interp_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int XEXP      = 6,
  parameter int YEXP      = 12,
  parameter int ENTRIES   = 8,
  parameter int SEG_SHIFT = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [IN_W-1:0] inX,
  output logic            outValid,
  output logic [YEXP:0]   outY
);

  stageStrobes_t strobes;

  sigmoid_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  sigmoid_datapath #(
    .IN_W      (IN_W),
    .XEXP      (XEXP),
    .YEXP      (YEXP),
    .ENTRIES   (ENTRIES),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inX     (inX),
    .outY    (outY)
  );

endmodule

// File: tb/sigmoid_interp_bench.sv
module sigmoid_interp_bench;

  localparam int NV = 18;
  localparam int VEC [NV] = '{0, 32, -32, 64, 100, -100, 1, -1, 128, 320,
                              447, 448, -447, -448, 5000, -5000, 32767, -32768};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inX = '0;
  logic        outValid;
  logic [12:0] outY;

  int nChecks = 0;
  int nFails = 0;
  int tab [8];
  bit done = 1'b0;

  always #5 clk = ~clk;

  sigmoid_interp u_sigmoid_interp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inX(inX),
    .outValid(outValid), .outY(outY)
  );

  function automatic int model(int x);
    int m;
    int i;
    int y;
    m = (x < 0) ? -x : x;
    i = m >>> 6;
    if (i >= 7) y = tab[7];
    else y = tab[i] + (((tab[i+1] - tab[i]) * (m & 63)) >>> 6);
    return (x < 0) ? 4096 - y : y;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) tab[i] = $rtoi(4096.0 / (1.0 + $exp(-real'(i))) + 0.5);
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid", int'(outValid), 0);
    check("R1 data", int'(outY), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(outY), 0);

    // R2..R7: back-to-back stream, each result checked three edges later
    for (int k = 0; k < NV + 3; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        check("R2 valid", int'(outValid), 1);
        check("R3-R7 value", int'(outY), model(VEC[k-3]));
      end
      if (k < NV) begin
        inValid = 1'b1;
        inX = 16'(VEC[k]);
      end else begin
        inValid = 1'b0;
        inX = 16'h1234;
      end
    end

    // R8: idle cycles hold the last result (-32768 -> 4)
    repeat (2) @(negedge clk);
    check("R8 valid low", int'(outValid), 0);
    check("R8 held", int'(outY), 4);

    // R3, R4, R7 direct anchors
    inValid = 1'b1; inX = 16'd0;
    @(negedge clk); inX = 16'd192;
    @(negedge clk); inX = 16'd448;
    @(negedge clk); inValid = 1'b0;
    check("R3 zero half", int'(outY), 2048); check("R3 valid", int'(outValid), 1);
    @(negedge clk); check("R4 breakpoint 3", int'(outY), 3902);
    @(negedge clk); check("R7 saturate", int'(outY), 4092);
    @(negedge clk); check("R8 gap valid", int'(outValid), 0);

    // R2/R8: bubble pattern valid, idle, valid
    inValid = 1'b1; inX = 16'hFFC0;           // -64
    @(negedge clk); inValid = 1'b0; inX = 16'd300;
    @(negedge clk); inValid = 1'b1; inX = 16'd96;
    @(negedge clk); inValid = 1'b0;
    check("R6 neg breakpoint", int'(outY), 4096 - 2994);
    @(negedge clk); check("R8 bubble valid", int'(outValid), 0);
    check("R8 bubble hold", int'(outY), 4096 - 2994);
    @(negedge clk); check("R5 interp 96", int'(outY), model(96));
    check("R2 bubble valid", int'(outValid), 1);

    // R1: reset mid-stream
    inValid = 1'b1; inX = 16'd50;
    @(negedge clk); rstN = 1'b0; inValid = 1'b0;
    @(negedge clk); check("R1 mid reset valid", int'(outValid), 0);
    check("R1 mid reset data", int'(outY), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 no stale output", int'(outValid), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule